// File: doc/BRIEF.md
# Serial Shift-and-Add Multiplier

This block multiplies two unsigned 8-bit operands and returns their 16-bit product. It works one multiplier bit per clock, using the radix-2 shift-and-add method. A single-cycle `start` pulse in the idle state captures both operands. Over the next eight clocks, the block conditionally adds a left-shifting copy of the multiplicand into an accumulator. The lowest bit of a right-shifting copy of the multiplier decides each add. On the following cycle the accumulator is moved into the product register and `done` pulses.

The datapath has one 16-bit adder and no other arithmetic unit. That adder is reused on every iteration. A small controller sequences the datapath through idle, iterate and finish states. A parameter selects how those states are encoded in flip-flops: plain binary, Gray, Johnson or one-hot. The encoding changes only the width and coding of the state register. The behaviour at the ports does not change.

Top module: `shiftadd_mult`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to idle and clears `product` to 0 and `done` to 0. This includes a reset that arrives in the middle of an operation, and no `done` pulse follows it.
- R2: A `start` sampled high in the idle state captures `opA` and `opB` on that edge. `done` rises after exactly OPW+1 = 9 further rising edges and is low after the 8th.
- R3: When `done` is high, `product` equals opA × opB as unsigned numbers for every operand pair, including 255 × 255 = 65025.
- R4: When either operand is zero, the product is 0 and the latency is the same as for any other pair.
- R5: `done` is high for exactly one clock cycle per operation.
- R6: `product` keeps its value from one completion to the next, including throughout the following operation.
- R7: A `start` sampled in any non-idle cycle is ignored. This covers the iteration cycles and the finishing cycle. Changes to `opA` or `opB` after the capturing edge have no effect on the result.
- R8: Parameter ENC picks the state code: 0 binary, 1 Gray, 2 Johnson, 3 one-hot. The state register is 2, 2, 2 and 3 bits wide respectively. Every encoding gives the same port behaviour cycle for cycle.
- R9: All additions pass through one 16-bit adder, and its carry-out is never set during an iteration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (honoured only when idle) |
| opA | input | OPW | Multiplicand |
| opB | input | OPW | Multiplier |
| product | output | 2*OPW | Registered product of the last completed operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The product and `done` are due on the ninth rising edge after the edge that samples `start`. The bench counts that many edges from the capture edge and samples on the falling edge that follows. It confirms that `done` is still low one edge earlier, and low again one edge later with `product` unchanged. All four encodings run side by side on the same stimulus, so any cycle slip in one of them shows up against both the arithmetic expectation and the others. The sweeps pair each value 0 to 255 with corner operands in both positions, then add random pairs. Some operations have stray `start` pulses injected mid-run and in the finishing cycle.

// File: rtl/shiftadd_pkg.sv
package shiftadd_pkg;

  typedef struct packed {
    logic load;     // capture operands, clear accumulator
    logic step;     // one add/shift iteration
    logic capture;  // move accumulator into product, pulse done
  } ctrl_t;

  localparam int ENC_BIN     = 0;
  localparam int ENC_GRAY    = 1;
  localparam int ENC_JOHNSON = 2;
  localparam int ENC_ONEHOT  = 3;

  localparam int N_STATES = 3;
  localparam int IDX_IDLE = 0;
  localparam int IDX_RUN  = 1;
  localparam int IDX_FIN  = 2;

  function automatic int stateBits(input int enc);
    case (enc)
      ENC_ONEHOT:  return N_STATES;
      ENC_JOHNSON: return (N_STATES + 1) / 2;
      default:     return $clog2(N_STATES);
    endcase
  endfunction

  function automatic logic [7:0] stateCode(input int enc, input int idx);
    logic [7:0] v;
    v = 8'(idx);
    case (enc)
      ENC_GRAY:    return v ^ (v >> 1);
      ENC_JOHNSON: return 8'((1 << idx) - 1);
      ENC_ONEHOT:  return 8'(1 << idx);
      default:     return v;
    endcase
  endfunction

endpackage

// File: rtl/shiftadd_adder.sv
module shiftadd_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry
);
  always_comb begin
    {carry, sum} = {1'b0, a} + {1'b0, b};
  end
endmodule

// File: rtl/shiftadd_ctrl.sv
module shiftadd_ctrl
  import shiftadd_pkg::*;
#(
  parameter int OPW = 8,
  parameter int ENC = ENC_BIN
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  output ctrl_t strobe
);
  localparam int SW = stateBits(ENC);
  localparam int CW = (OPW > 1) ? $clog2(OPW) : 1;
  localparam logic [SW-1:0] S_IDLE = SW'(stateCode(ENC, IDX_IDLE));
  localparam logic [SW-1:0] S_RUN  = SW'(stateCode(ENC, IDX_RUN));
  localparam logic [SW-1:0] S_FIN  = SW'(stateCode(ENC, IDX_FIN));

  logic [SW-1:0] stateQ, stateD;
  logic [CW-1:0] iterQ;
  logic isIdle, isRun, isFin, lastIter;

  assign isIdle   = (stateQ == S_IDLE);
  assign isRun    = (stateQ == S_RUN);
  assign isFin    = (stateQ == S_FIN);
  assign lastIter = (iterQ == CW'(OPW - 1));

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    if (isIdle) begin
      if (start) begin
        strobe.load = 1'b1;
        stateD      = S_RUN;
      end
    end else if (isRun) begin
      strobe.step = 1'b1;
      if (lastIter) stateD = S_FIN;
    end else if (isFin) begin
      strobe.capture = 1'b1;
      stateD         = S_IDLE;
    end else begin
      stateD = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= S_IDLE;
      iterQ  <= '0;
    end else begin
      stateQ <= stateD;
      if (strobe.load)      iterQ <= '0;
      else if (strobe.step) iterQ <= iterQ + 1'b1;
    end
  end

  // R8
  state_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (isIdle || isRun || isFin));

  // R2
  iter_count_chk: assert property (@(posedge clk) disable iff (rst)
    (isRun && lastIter) |=> isFin);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!isIdle) |-> !strobe.load);

  generate
    if (ENC == ENC_ONEHOT) begin : g_onehot
      // R8
      onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(stateQ) == 1));
    end
  endgenerate
endmodule

// File: rtl/shiftadd_dpath.sv
module shiftadd_dpath
  import shiftadd_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             strobe,
  input  logic [OPW-1:0]    opA,
  input  logic [OPW-1:0]    opB,
  output logic [2*OPW-1:0]  product,
  output logic              done
);
  localparam int PW = 2 * OPW;

  logic [PW-1:0]  mcandQ, accQ, prodQ, addend, sum;
  logic [OPW-1:0] mplierQ;
  logic           doneQ, carry;

  assign addend = mplierQ[0] ? mcandQ : '0;

  shiftadd_adder #(.W(PW)) u_add (
    .a     (accQ),
    .b     (addend),
    .sum   (sum),
    .carry (carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcandQ  <= '0;
      mplierQ <= '0;
      accQ    <= '0;
      prodQ   <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= strobe.capture;
      if (strobe.load) begin
        mcandQ  <= {{OPW{1'b0}}, opA};
        mplierQ <= opB;
        accQ    <= '0;
      end else if (strobe.step) begin
        accQ    <= sum;
        mcandQ  <= mcandQ << 1;
        mplierQ <= mplierQ >> 1;
      end
      if (strobe.capture) prodQ <= accQ;
    end
  end

  assign product = prodQ;
  assign done    = doneQ;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.step |-> !carry);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);

  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> $stable(prodQ));
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult
  import shiftadd_pkg::*;
#(
  parameter int OPW = 8,
  parameter int ENC = ENC_BIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OPW-1:0]   opA,
  input  logic [OPW-1:0]   opB,
  output logic [2*OPW-1:0] product,
  output logic             done
);
  ctrl_t strobe;

  shiftadd_ctrl #(.OPW(OPW), .ENC(ENC)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobe (strobe)
  );

  shiftadd_dpath #(.OPW(OPW)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .product (product),
    .done    (done)
  );
endmodule

// File: tb/shiftadd_mult_tb.sv
`timescale 1ns/1ps
module shiftadd_mult_tb;
  localparam int OPW = 8;
  localparam int NENC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [OPW-1:0] opA = '0, opB = '0;
  logic [2*OPW-1:0] prodV [NENC];
  logic doneV [NENC];

  int nChecks = 0;
  int nFails  = 0;
  int prevExp = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  for (genvar e = 0; e < NENC; e++) begin : g_enc
    shiftadd_mult #(.OPW(OPW), .ENC(e)) u_dut (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .opA     (opA),
      .opB     (opB),
      .product (prodV[e]),
      .done    (doneV[e])
    );
  end

  task automatic chk(input bit ok, input string tag, input int enc,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s enc=%0d actual=%0d expected=%0d", tag, enc, act, exp);
    end
  endtask

  task automatic checkDone(input bit expDone, input string tag);
    for (int e = 0; e < NENC; e++)
      chk(doneV[e] == expDone, tag, e, int'(doneV[e]), int'(expDone));
  endtask

  task automatic checkProd(input int expP, input string tag);
    for (int e = 0; e < NENC; e++)
      chk(int'(prodV[e]) == expP, tag, e, int'(prodV[e]), expP);
  endtask

  // Called at a falling edge; returns at the falling edge after done falls.
  task automatic runOp(input int a, input int b, input bit inject);
    int expP;
    expP  = a * b;
    opA   = OPW'(a);
    opB   = OPW'(b);
    start = 1'b1;
    @(posedge clk);                // capture edge
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      if (inject && k == 3) begin
        start = 1'b1; opA = ~OPW'(a); opB = ~OPW'(b);   // R7 stray start
      end else if (inject && k == 4) begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    checkDone(1'b0, "R2 early");
    checkProd(prevExp, "R6 hold");
    if (inject) begin
      start = 1'b1; opA = ~OPW'(a); opB = ~OPW'(b);     // R7 finish-cycle start
    end
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    checkDone(1'b1, "R2 due");
    if (a == 0 || b == 0) checkProd(0, "R4 zero");
    else if (inject)      checkProd(expP, "R7 ignored");
    else if (a == 255 && b == 255) checkProd(expP, "R9 max");
    else                  checkProd(expP, "R3 product");
    for (int e = 1; e < NENC; e++)
      chk(prodV[e] == prodV[0], "R8 match", e, int'(prodV[e]), int'(prodV[0]));
    @(posedge clk);
    @(negedge clk);
    checkDone(1'b0, "R5 pulse");
    checkProd(expP, "R6 keep");
    prevExp = expP;
  endtask

  initial begin
    int corners [6] = '{0, 1, 2, 128, 254, 255};
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkDone(1'b0, "R1 reset");
    checkProd(0, "R1 reset");
    rst = 1'b0;
    @(negedge clk);

    runOp(255, 255, 1'b0);
    for (int a = 0; a < 256; a++)
      for (int c = 0; c < 6; c++) runOp(a, corners[c], 1'b0);
    for (int b = 0; b < 256; b++)
      for (int c = 0; c < 6; c++) runOp(corners[c], b, (b % 7) == 0);
    for (int i = 0; i < 400; i++)
      runOp(int'($urandom_range(255)), int'($urandom_range(255)), (i % 5) == 0);

    // R1: reset in mid-operation
    opA = 8'd200; opB = 8'd100; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    checkDone(1'b0, "R1 midrun");
    checkProd(0, "R1 midrun");
    rst = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); @(negedge clk);
      checkDone(1'b0, "R1 no done");
    end
    prevExp = 0;
    runOp(13, 11, 1'b0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule